// File: doc/BRIEF.md
# Ripple-Blanked Seven-Segment Display Chain

This block turns a row of BCD digits into active-low seven-segment patterns for a multi-digit display, with leading zeros suppressed. Each digit has its own decoder. A blanking flag ripples from left to right: a decoder blanks its zero digit only while every digit to its left has also been blanked. Once a digit is shown, the decoder passes a 0 to its right-hand neighbour, and every digit after that is shown.

A parameter sets how many of the rightmost digits are fractional. Those digits, and the least significant digit in every case, ignore the ripple and always show their value. A decimal-point output, also active-low, lights on the digit just left of the fractional digits. The block has no clock or state. It is placed between a binary-to-BCD stage and the display pins.

Top module: `rb_seg_chain`

## Requirements
- R1: A digit code 0 to 9 that is shown drives the active-low glyph on its 7-bit segment field. Bit 0 is the top bar, bits 1 to 5 go clockwise (upper-right, lower-right, bottom, lower-left, upper-left), and bit 6 is the middle bar. Examples: 0 gives 7'h40, 1 gives 7'h79, 8 gives 7'h00, 9 gives 7'h10.
- R2: Codes 10 to 15 drive all segments off (7'h7F), whatever the ripple state.
- R3: A decoder's ripple output is 1 exactly when its ripple input is 1 and its code is 0. It feeds the ripple input of the next digit to the right.
- R4: The leftmost digit's ripple input is 1, so a run of leading zeros shows blank (7'h7F).
- R5: The least significant digit, and the FRAC_DIGITS rightmost digits, have their ripple input forced to 0, so a zero there shows as 7'h40.
- R6: An invalid code inside a leading-zero run is blanked but ends the run, so a 0 to its right shows as a glyph.
- R7: dpOut is active-low with one bit per digit. Only the bit of digit index FRAC_DIGITS is 0, and only when FRAC_DIGITS > 0. That bit stays 0 even if the digit is blanked.
- R8: The outputs depend only on the present inputs, with no clock or storage. With FRAC_DIGITS=1, the digits 0,0,9,5 show blank, blank, 9, 5 and the digits 0,8,3,4 show blank, 8, 3, 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| digitsIn | input | 4*NUM_DIGITS | BCD codes. Digit i is in bits [4i+3:4i]; digit NUM_DIGITS-1 is the leftmost |
| segOut | output | 7*NUM_DIGITS | Active-low segment fields. Digit i is in bits [7i+6:7i] |
| dpOut | output | NUM_DIGITS | Active-low decimal point, one bit per digit |

## Verification
The bench drives every one of the 65536 input combinations and compares all outputs with a behavioural model. It also runs directed cases.

The corner cases are these:
- A zero run that reaches the fractional boundary. A design that let the ripple through there would blank the fractional zeros of "0.0".
- An invalid code in the middle of a zero run. A design that passed the ripple through it would blank the zeros that follow.
- All-zero input. It must show exactly one "0", with the decimal point kept.
- A nonzero digit after a zero run. A design with a stuck ripple would blank the zeros to its right.

A wrong segment bit order shows up as mismatched glyph values.

// File: rtl/rb_seg_pkg.sv
package rb_seg_pkg;
  localparam int DIGIT_W    = 4;
  localparam int SEG_W      = 7;
  localparam int MAX_DIGITS = 8;

  localparam logic [SEG_W-1:0] SEG_BLANK = 7'h7F;

  // control strobes handed to the datapath
  typedef struct packed {
    logic [MAX_DIGITS-1:0] forceShow;  // ripple input forced to 0
    logic                  leftTie;    // value fed into leftmost ripple input
    logic [MAX_DIGITS-1:0] dpLit;      // decimal point enable per digit
  } chainCtrl_t;
endpackage

// File: rtl/rb_seg_digit.sv
module rb_seg_digit
  import rb_seg_pkg::*;
(
  input  logic [DIGIT_W-1:0] value,
  input  logic               rbIn,
  output logic               rbOut,
  output logic [SEG_W-1:0]   segments
);
  logic [SEG_W-1:0] glyph;

  always_comb begin
    unique case (value)
      4'd0:    glyph = 7'h40;
      4'd1:    glyph = 7'h79;
      4'd2:    glyph = 7'h24;
      4'd3:    glyph = 7'h30;
      4'd4:    glyph = 7'h19;
      4'd5:    glyph = 7'h12;
      4'd6:    glyph = 7'h02;
      4'd7:    glyph = 7'h78;
      4'd8:    glyph = 7'h00;
      4'd9:    glyph = 7'h10;
      default: glyph = SEG_BLANK;
    endcase
  end

  always_comb begin
    if (rbIn && value == '0) begin
      segments = SEG_BLANK;
      rbOut    = 1'b1;
    end else begin
      segments = glyph;
      rbOut    = 1'b0;
    end
  end

  always_comb begin
    if (!$isunknown({value, rbIn})) begin
      // R2
      invalid_dark_chk: assert (value <= 4'd9 || segments == SEG_BLANK);
      // R3
      rb_pass_chk: assert (!rbOut || (rbIn && segments == SEG_BLANK));
      // R3
      rb_stop_chk: assert (rbOut || !rbIn || value != '0);
    end
  end
endmodule

// File: rtl/rb_seg_ctrl.sv
module rb_seg_ctrl
  import rb_seg_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int FRAC_DIGITS = 1
) (
  output chainCtrl_t ctrlS
);
  localparam int FORCED = (FRAC_DIGITS > 0) ? FRAC_DIGITS : 1;

  always_comb begin
    ctrlS = '0;
    ctrlS.leftTie = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      ctrlS.forceShow[i] = (i < FORCED);
      ctrlS.dpLit[i]     = (FRAC_DIGITS > 0) && (i == FRAC_DIGITS);
    end
  end
endmodule

// File: rtl/rb_seg_datapath.sv
module rb_seg_datapath
  import rb_seg_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  chainCtrl_t                    ctrlS,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsIn,
  output logic [NUM_DIGITS*SEG_W-1:0]   segOut,
  output logic [NUM_DIGITS-1:0]         dpOut
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    logic rbInW;
    logic rbOutW;
    if (i == NUM_DIGITS-1) begin : g_left
      assign rbInW = ctrlS.forceShow[i] ? 1'b0 : ctrlS.leftTie;
    end else begin : g_chain
      assign rbInW = ctrlS.forceShow[i] ? 1'b0 : g_dig[i+1].rbOutW;
    end

    rb_seg_digit u_digit (
      .value    (digitsIn[i*DIGIT_W +: DIGIT_W]),
      .rbIn     (rbInW),
      .rbOut    (rbOutW),
      .segments (segOut[i*SEG_W +: SEG_W])
    );

    assign dpOut[i] = ~ctrlS.dpLit[i];
  end

  always_comb begin
    if (!$isunknown(digitsIn)) begin
      // R7
      dp_single_chk: assert ($onehot0(~dpOut));
      // R5
      lsd_shown_chk: assert (digitsIn[DIGIT_W-1:0] != '0 || segOut[SEG_W-1:0] == 7'h40);
    end
  end
endmodule

// File: rtl/rb_seg_chain.sv
module rb_seg_chain
  import rb_seg_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int FRAC_DIGITS = 1
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] digitsIn,
  output logic [NUM_DIGITS*SEG_W-1:0]   segOut,
  output logic [NUM_DIGITS-1:0]         dpOut
);
  chainCtrl_t ctrlS;

  rb_seg_ctrl #(.NUM_DIGITS(NUM_DIGITS), .FRAC_DIGITS(FRAC_DIGITS)) u_ctrl (
    .ctrlS (ctrlS)
  );

  rb_seg_datapath #(.NUM_DIGITS(NUM_DIGITS)) u_dp (
    .ctrlS    (ctrlS),
    .digitsIn (digitsIn),
    .segOut   (segOut),
    .dpOut    (dpOut)
  );
endmodule

// File: tb/rb_seg_chain_bench.sv
module rb_seg_chain_bench;
  localparam int N = 4;
  localparam int F = 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N*4-1:0] digitsIn;
  logic [N*7-1:0] segOut;
  logic [N-1:0]   dpOut;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  rb_seg_chain #(.NUM_DIGITS(N), .FRAC_DIGITS(F)) u_rb_seg_chain (
    .digitsIn (digitsIn),
    .segOut   (segOut),
    .dpOut    (dpOut)
  );

  // active-high a..g sets, inverted for the low-true display
  function automatic logic [6:0] lit(input int v);
    logic [6:0] on;
    case (v)
      0: on = 7'b0111111; 1: on = 7'b0000110; 2: on = 7'b1011011;
      3: on = 7'b1001111; 4: on = 7'b1100110; 5: on = 7'b1101101;
      6: on = 7'b1111101; 7: on = 7'b0000111; 8: on = 7'b1111111;
      9: on = 7'b1101111; default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

  // behavioural model: scan from the left while leading zeros continue
  task automatic checkAll(input logic [N*4-1:0] d, input string tag);
    bit leading = 1;
    int forcedCnt = (F > 0) ? F : 1;
    for (int i = N-1; i >= 0; i--) begin
      int v = int'(d[i*4 +: 4]);
      logic [6:0] exp;
      string t;
      if (i < forcedCnt) begin
        exp = lit(v); t = (v > 9) ? "R2" : "R5";
        leading = 0;
      end else if (leading && v == 0) begin
        exp = 7'h7F; t = "R4";
      end else begin
        exp = lit(v); t = (v > 9) ? "R2" : "R1";
        leading = 0;
      end
      if (tag != "") t = tag;
      total++;
      if (segOut[i*7 +: 7] !== exp) begin
        bad++;
        $display("FAIL %s digit %0d in=%h seg act=%h exp=%h", t, i, d, segOut[i*7 +: 7], exp);
      end
    end
    begin
      logic [N-1:0] dpExp = '1;
      if (F > 0) dpExp[F] = 1'b0;
      total++;
      if (dpOut !== dpExp) begin
        bad++;
        $display("FAIL R7 in=%h dp act=%b exp=%b", d, dpOut, dpExp);
      end
    end
  endtask

  task automatic expectSeg(input int idx, input logic [6:0] exp, input string t);
    total++;
    if (segOut[idx*7 +: 7] !== exp) begin
      bad++;
      $display("FAIL %s digit %0d act=%h exp=%h", t, idx, segOut[idx*7 +: 7], exp);
    end
  endtask

  task automatic apply(input logic [N*4-1:0] d);
    @(posedge clk);
    digitsIn = d;
    @(negedge clk);
  endtask

  initial begin
    digitsIn = '0;
    @(negedge clk);
    // reset-like all-zero state: single 0 shown, point kept
    checkAll('0, "R5");
    expectSeg(1, 7'h7F, "R4");
    expectSeg(0, 7'h40, "R5");

    apply(16'h0095);                 // shows "9.5"
    expectSeg(3, 7'h7F, "R8"); expectSeg(2, 7'h7F, "R8");
    expectSeg(1, 7'h10, "R8"); expectSeg(0, 7'h12, "R8");
    apply(16'h0834);                 // shows "83.4"
    expectSeg(3, 7'h7F, "R8"); expectSeg(2, 7'h00, "R8");
    expectSeg(1, 7'h30, "R8"); expectSeg(0, 7'h19, "R8");

    apply(16'h0A00);                 // invalid code ends the run
    expectSeg(3, 7'h7F, "R4"); expectSeg(2, 7'h7F, "R6");
    expectSeg(1, 7'h40, "R6");
    apply(16'h1000);                 // ripple stops after a shown digit
    expectSeg(3, 7'h79, "R3"); expectSeg(2, 7'h40, "R3");
    expectSeg(1, 7'h40, "R3");
    apply(16'hFFFF);
    checkAll(16'hFFFF, "R2");
    apply(16'h8888);
    checkAll(16'h8888, "R1");

    for (int k = 0; k < 65536; k++) begin
      apply(16'(k));
      checkAll(16'(k), "");
    end
    done = 1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) if (done) begin
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule